// File: doc/BRIEF.md
# Dual Programmable Reload Down-Timer

This block contains two independent down-counting timers of `CNT_W` bits (8 by default). Each timer has a reload register, a run request bit, a selectable count source, an underflow interrupt flag and a toggling timer output with an enable gate. Every timer reloads continuously. The count sources are two slow-changing clock levels, `clk_slow` and `clk_fast`. Both are sampled on the single system clock `clk`. A timer acts only on the falling and rising edges of its selected source, as seen in that sample stream.

A nibble-wide register port sets up the timers and reads them back. Address bit 3 selects the channel and bits 2..0 select the register within it. The count is read as two nibbles, and reading the low nibble freezes the high nibble for the read that follows. Run and stop requests wait for the next falling edge of the selected source. A stop lets one more decrement happen first. The run bit reads back as 1 until the timer has really halted.

Each channel is a four-state machine:
- **ST_STOP**: idle.
- **ST_RUN**: counting.
- **ST_RLD_RUN**: reload pending, then resume counting.
- **ST_RLD_STOP**: reload pending, then halt.

Its transitions are:
- **start**: ST_STOP→ST_RUN on a falling edge while run is requested.
- **halt**: ST_RUN→ST_STOP on a falling edge with no run request and a nonzero count.
- **underflow**: ST_RUN→ST_RLD_RUN or ST_RLD_STOP on a falling edge at count 00.
- **reload-resume**: ST_RLD_RUN→ST_RUN on a rising edge.
- **reload-halt**: ST_RLD_STOP→ST_STOP on a rising edge.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, the following are all 0 for both channels: count, reload value, run bit, source select (0 = slow), output enable, interrupt flag and the `tout` output.
- R2: A run request written as 1 at register offset 0, bit 0, takes effect only at the next falling edge of the selected source. That edge starts the timer without decrementing, and the count does not change before it.
- R3: When 0 is written to the run bit of a counting timer, the next falling edge still decrements once and then the timer halts. Offset 0, bit 0 reads back as 1 until the halt has happened, and no later edge changes the count.
- R4: While running, the count drops by one on each falling edge of the selected source. Rising edges and steady levels leave it unchanged, except for the reload in R5.
- R5: A falling edge while the running count is 00 is an underflow. It sets the interrupt flag on that edge and the count stays 00. The next rising edge loads the reload value, so a reload of 25h gives the sequence 01h, 00h, 25h, 24h.
- R6: The interrupt flag reads at offset 0, bit 3. Writing offset 0 with bit 3 = 1 clears it, and writing bit 3 = 0 leaves it set. The flag drives `irq`.
- R7: Offset 0, bit 1 selects the count source: 0 = `clk_slow`, 1 = `clk_fast`. Edges on the source that is not selected have no effect on that channel.
- R8: Reading offset 3 returns count bits 3..0 and captures count bits 7..4. Reading offset 4 returns that captured nibble, even if the count has changed since.
- R9: Each underflow toggles an internal output bit. `tout` equals that bit while offset 0, bit 2 (output enable) is 1, and is 0 while it is 0.
- R10: Offset 1 and offset 2 hold the reload low and high nibbles and read back as written. Offsets 5 to 7 read 0. Each channel is affected only by writes whose address bit 3 selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_slow | input | 1 | Low-speed count source level, synchronous to clk |
| clk_fast | input | 1 | High-speed count source level, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect: nibble capture) |
| addr | input | 4 | Bit 3 channel, bits 2..0 register offset |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data, combinational from addr |
| irq | output | 2 | Per-channel interrupt flag |
| tout | output | 2 | Per-channel gated timer output |

## Verification
The bench builds the block with its defaults: two channels and an 8-bit count. This keeps every count value and every wrap through 00 reachable within a few hundred source edges. Reload values such as 10h and 25h put a nibble carry and an underflow next to one another. Because of this, the nibble-capture read and the delayed-reload window are exercised directly. A random phase then toggles the fast source often and the slow source rarely, with writes and reads to any address. This mixes source switches, stops during reload, and writes that coincide with edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_RUN      = 2'd1,
        ST_RLD_RUN  = 2'd2,
        ST_RLD_STOP = 2'd3
    } tmr_state_e;

    localparam int OFS_W = 3;

    localparam logic [OFS_W-1:0] OFS_CTRL   = 3'd0;
    localparam logic [OFS_W-1:0] OFS_RLD_LO = 3'd1;
    localparam logic [OFS_W-1:0] OFS_RLD_HI = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CNT_LO = 3'd3;
    localparam logic [OFS_W-1:0] OFS_CNT_HI = 3'd4;

    localparam int CB_RUN = 0;
    localparam int CB_SRC = 1;
    localparam int CB_OE  = 2;
    localparam int CB_IRQ = 3;

    localparam int N_SRC = 2;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int N_LVL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_LVL-1:0] lvl,
    output logic [N_LVL-1:0] fall,
    output logic [N_LVL-1:0] rise
);

    logic [N_LVL-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
    assign rise = ~prev_q & lvl;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_fall,
    input  logic [N_SRC-1:0]   src_rise,
    input  logic               wr_ctrl,
    input  logic               wr_rld_lo,
    input  logic               wr_rld_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W-1:0]   reload,
    output logic               run_req,
    output logic               busy,
    output logic               src_sel,
    output logic               out_en,
    output logic               irq,
    output logic               tout,
    output logic               sel_fall,
    output logic               sel_rise
);

    localparam int NIB_W = CNT_W / 2;

    tmr_state_e state_q, state_d;
    logic       do_dec, do_undf, do_load;
    logic       tog_q;

    assign sel_fall = src_fall[src_sel];
    assign sel_rise = src_rise[src_sel];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (sel_fall && run_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (sel_fall) begin
                    if (count == '0)  state_d = run_req ? ST_RLD_RUN : ST_RLD_STOP;
                    else if (!run_req) state_d = ST_STOP;
                end
            end
            ST_RLD_RUN: begin
                if (sel_rise) state_d = ST_RUN;
            end
            ST_RLD_STOP: begin
                if (sel_rise) state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // per-state actions
    always_comb begin
        do_dec  = 1'b0;
        do_undf = 1'b0;
        do_load = 1'b0;
        unique case (state_q)
            ST_STOP:     ;
            ST_RUN: begin
                do_dec  = sel_fall && (count != '0);
                do_undf = sel_fall && (count == '0);
            end
            ST_RLD_RUN,
            ST_RLD_STOP: do_load = sel_rise;
            default:     ;
        endcase
    end

    assign busy = (state_q != ST_STOP);

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (do_load) count <= reload;
        else if (do_dec)  count <= count - 1'b1;
    end

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload  <= '0;
            run_req <= 1'b0;
            src_sel <= 1'b0;
            out_en  <= 1'b0;
        end else begin
            if (wr_rld_lo) reload[NIB_W-1:0]     <= wdata;
            if (wr_rld_hi) reload[CNT_W-1:NIB_W] <= wdata;
            if (wr_ctrl) begin
                run_req <= wdata[CB_RUN];
                src_sel <= wdata[CB_SRC];
                out_en  <= wdata[CB_OE];
            end
        end
    end

    // interrupt flag: set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        irq <= 1'b0;
        else if (do_undf)                  irq <= 1'b1;
        else if (wr_ctrl && wdata[CB_IRQ]) irq <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tog_q <= 1'b0;
        else if (do_undf) tog_q <= ~tog_q;
    end

    assign tout = tog_q & out_en;

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int N_CH  = 2,
    parameter int CNT_W = 8,
    parameter int CH_W  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [CH_W+OFS_W-1:0]      addr,
    input  logic [N_CH-1:0][CNT_W-1:0] ch_cnt,
    input  logic [N_CH-1:0][CNT_W-1:0] ch_rld,
    input  logic [N_CH-1:0]            ch_run,
    input  logic [N_CH-1:0]            ch_busy,
    input  logic [N_CH-1:0]            ch_src,
    input  logic [N_CH-1:0]            ch_oe,
    input  logic [N_CH-1:0]            ch_irq,
    output logic [N_CH-1:0]            wr_ctrl,
    output logic [N_CH-1:0]            wr_lo,
    output logic [N_CH-1:0]            wr_hi,
    output logic [CNT_W/2-1:0]         rdata
);

    localparam int NIB_W = CNT_W / 2;

    logic [CH_W-1:0]  a_ch;
    logic [OFS_W-1:0] a_ofs;
    logic [N_CH-1:0][NIB_W-1:0] hold_q;

    assign a_ch  = addr[CH_W+OFS_W-1:OFS_W];
    assign a_ofs = addr[OFS_W-1:0];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic hit;
        assign hit        = (a_ch == CH_W'(c));
        assign wr_ctrl[c] = wr_en && hit && (a_ofs == OFS_CTRL);
        assign wr_lo[c]   = wr_en && hit && (a_ofs == OFS_RLD_LO);
        assign wr_hi[c]   = wr_en && hit && (a_ofs == OFS_RLD_HI);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                hold_q[c] <= '0;
            else if (rd_en && hit && (a_ofs == OFS_CNT_LO))
                hold_q[c] <= ch_cnt[c][CNT_W-1:NIB_W];
        end
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (a_ch == CH_W'(c)) begin
                unique case (a_ofs)
                    OFS_CTRL: begin
                        rdata[CB_RUN] = ch_run[c] | ch_busy[c];
                        rdata[CB_SRC] = ch_src[c];
                        rdata[CB_OE]  = ch_oe[c];
                        rdata[CB_IRQ] = ch_irq[c];
                    end
                    OFS_RLD_LO: rdata = ch_rld[c][NIB_W-1:0];
                    OFS_RLD_HI: rdata = ch_rld[c][CNT_W-1:NIB_W];
                    OFS_CNT_LO: rdata = ch_cnt[c][NIB_W-1:0];
                    OFS_CNT_HI: rdata = hold_q[c];
                    default:    rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import tmr_pkg::*;
#(
    parameter  int N_CH   = 2,
    parameter  int CNT_W  = 8,
    localparam int CH_W   = $clog2(N_CH),
    localparam int ADDR_W = CH_W + OFS_W,
    localparam int NIB_W  = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_slow,
    input  logic              clk_fast,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  wdata,
    output logic [NIB_W-1:0]  rdata,
    output logic [N_CH-1:0]   irq,
    output logic [N_CH-1:0]   tout
);

    logic [N_SRC-1:0]            src_fall, src_rise;
    logic [N_CH-1:0][CNT_W-1:0]  ch_cnt, ch_rld;
    logic [N_CH-1:0]             ch_run, ch_busy, ch_src, ch_oe;
    logic [N_CH-1:0]             ch_fall, ch_rise;
    logic [N_CH-1:0]             wr_ctrl, wr_lo, wr_hi;

    tmr_edge_det #(.N_LVL(N_SRC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({clk_fast, clk_slow}),
        .fall (src_fall),
        .rise (src_rise)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_tmr
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_fall (src_fall),
            .src_rise (src_rise),
            .wr_ctrl  (wr_ctrl[c]),
            .wr_rld_lo(wr_lo[c]),
            .wr_rld_hi(wr_hi[c]),
            .wdata    (wdata),
            .count    (ch_cnt[c]),
            .reload   (ch_rld[c]),
            .run_req  (ch_run[c]),
            .busy     (ch_busy[c]),
            .src_sel  (ch_src[c]),
            .out_en   (ch_oe[c]),
            .irq      (irq[c]),
            .tout     (tout[c]),
            .sel_fall (ch_fall[c]),
            .sel_rise (ch_rise[c])
        );
    end

    tmr_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .CH_W(CH_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .ch_cnt (ch_cnt),
        .ch_rld (ch_rld),
        .ch_run (ch_run),
        .ch_busy(ch_busy),
        .ch_src (ch_src),
        .ch_oe  (ch_oe),
        .ch_irq (irq),
        .wr_ctrl(wr_ctrl),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .rdata  (rdata)
    );

endmodule

// File: rtl/dual_reload_timer_chk.sv
module dual_reload_timer_chk #(
    parameter int N_CH  = 2,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_CH-1:0]            ch_fall,
    input logic [N_CH-1:0]            ch_rise,
    input logic [N_CH-1:0]            ch_busy,
    input logic [N_CH-1:0]            ch_oe,
    input logic [N_CH-1:0][CNT_W-1:0] ch_cnt,
    input logic [N_CH-1:0]            irq,
    input logic [N_CH-1:0]            tout
);

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        // R4: with no edge on the selected source the count holds
        p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_fall[i] && !ch_rise[i]) |=> $stable(ch_cnt[i]));

        // R2: leaving the stopped state needs a falling edge
        p_start_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_busy[i]) |-> $past(ch_fall[i]));

        // R3: entering the stopped state needs a source edge
        p_halt_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_busy[i]) |-> $past(ch_fall[i] || ch_rise[i]));

        // R5: the interrupt flag rises only after a falling edge
        p_irq_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[i]) |-> $past(ch_fall[i]));

        // R9: with the output enabled, a toggle follows a falling edge
        p_tout_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_oe[i] && $past(ch_oe[i]) && (tout[i] != $past(tout[i])))
                |-> $past(ch_fall[i]));
    end

endmodule

bind dual_reload_timer dual_reload_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ch_fall(ch_fall),
    .ch_rise(ch_rise),
    .ch_busy(ch_busy),
    .ch_oe  (ch_oe),
    .ch_cnt (ch_cnt),
    .irq    (irq),
    .tout   (tout)
);

// File: tb/dual_reload_timer_bench.sv
module dual_reload_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_slow = 1'b0, clk_fast = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0, wdata = '0;
    logic [3:0] rdata;
    logic [1:0] irq, tout;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_reload_timer u_dual_reload_timer (
        .clk(clk), .rst_n(rst_n), .clk_slow(clk_slow), .clk_fast(clk_fast),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .tout(tout)
    );

    // reference model (0 stop, 1 run, 2 reload->run, 3 reload->stop)
    int         m_st  [2];
    logic [7:0] m_cnt [2], m_rld [2];
    logic       m_run [2], m_src [2], m_oe [2], m_irq [2], m_tog [2];
    logic [3:0] m_hold[2];
    logic       p_slow = 1'b0, p_fast = 1'b0;
    logic       s_lvl = 1'b0, f_lvl = 1'b0;
    logic [3:0] last_rd;
    logic [1:0] last_irq, last_tout;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] model_read(input logic [3:0] a);
        int c = a[3];
        case (a[2:0])
            3'd0:    return {m_irq[c], m_oe[c], m_src[c], m_run[c] | (m_st[c] != 0)};
            3'd1:    return m_rld[c][3:0];
            3'd2:    return m_rld[c][7:4];
            3'd3:    return m_cnt[c][3:0];
            3'd4:    return m_hold[c];
            default: return 4'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        case (a[2:0])
            3'd0:      return "R3/R6 ctrl readback";
            3'd3, 3'd4: return "R8 count nibble";
            default:   return "R10 register readback";
        endcase
    endfunction

    task automatic model_step(input logic sl, input logic fa, input logic we,
                              input logic re, input logic [3:0] a, input logic [3:0] d);
        for (int c = 0; c < 2; c++) begin
            logic       cur, prv, fall, rise, undf;
            int         nst;
            logic [7:0] ncnt;
            cur  = m_src[c] ? fa : sl;
            prv  = m_src[c] ? p_fast : p_slow;
            fall = prv & ~cur;
            rise = ~prv & cur;
            nst  = m_st[c];
            ncnt = m_cnt[c];
            undf = 1'b0;
            case (m_st[c])
                0: if (fall && m_run[c]) nst = 1;
                1: if (fall) begin
                       if (m_cnt[c] == 8'h00) begin
                           undf = 1'b1;
                           nst  = m_run[c] ? 2 : 3;
                       end else begin
                           ncnt = m_cnt[c] - 8'd1;
                           if (!m_run[c]) nst = 0;
                       end
                   end
                2: if (rise) begin ncnt = m_rld[c]; nst = 1; end
                default: if (rise) begin ncnt = m_rld[c]; nst = 0; end
            endcase
            if (re && a[3] == c[0] && a[2:0] == 3'd3) m_hold[c] = m_cnt[c][7:4];
            if (undf) m_irq[c] = 1'b1;
            else if (we && a[3] == c[0] && a[2:0] == 3'd0 && d[3]) m_irq[c] = 1'b0;
            if (undf) m_tog[c] = ~m_tog[c];
            m_st[c]  = nst;
            m_cnt[c] = ncnt;
            if (we && a[3] == c[0]) begin
                case (a[2:0])
                    3'd0: begin m_run[c] = d[0]; m_src[c] = d[1]; m_oe[c] = d[2]; end
                    3'd1: m_rld[c][3:0] = d;
                    3'd2: m_rld[c][7:4] = d;
                    default: ;
                endcase
            end
        end
        p_slow = sl;
        p_fast = fa;
    endtask

    task automatic tick(input logic sl, input logic fa, input logic we, input logic re,
                        input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        clk_slow = sl; clk_fast = fa; wr_en = we; rd_en = re; addr = a; wdata = d;
        #1;
        last_irq  = irq;
        last_tout = tout;
        last_rd   = rdata;
        for (int c = 0; c < 2; c++) begin
            check("R5/R6 irq flag", {7'd0, irq[c]}, {7'd0, m_irq[c]});
            check("R9 tout", {7'd0, tout[c]}, {7'd0, m_tog[c] & m_oe[c]});
        end
        if (re) check(read_tag(a), {4'd0, rdata}, {4'd0, model_read(a)});
        @(posedge clk);
        model_step(sl, fa, we, re, a, d);
    endtask

    task automatic idle();                         tick(s_lvl, f_lvl, 1'b0, 1'b0, 4'h0, 4'h0); endtask
    task automatic wr(input logic [3:0] a, input logic [3:0] d); tick(s_lvl, f_lvl, 1'b1, 1'b0, a, d); endtask
    task automatic rd_lit(input logic [3:0] a, input logic [3:0] exp, input string tag);
        tick(s_lvl, f_lvl, 1'b0, 1'b1, a, 4'h0);
        check(tag, {4'd0, last_rd}, {4'd0, exp});
    endtask
    task automatic slow_to(input logic v); s_lvl = v; idle(); endtask
    task automatic fast_to(input logic v); f_lvl = v; idle(); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_st[c] = 0; m_cnt[c] = '0; m_rld[c] = '0; m_run[c] = 0; m_src[c] = 0;
            m_oe[c] = 0; m_irq[c] = 0; m_tog[c] = 0; m_hold[c] = '0;
        end
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_lit(4'h0, 4'h0, "R1 ctrl ch0");
        rd_lit(4'h8, 4'h0, "R1 ctrl ch1");
        rd_lit(4'h3, 4'h0, "R1 count ch0");
        rd_lit(4'h1, 4'h0, "R1 reload ch0");
        check("R1 irq", {6'd0, last_irq}, 8'd0);
        check("R1 tout", {6'd0, last_tout}, 8'd0);
        rd_lit(4'h5, 4'h0, "R10 unused offset");

        // ch0: reload 25h, slow source
        slow_to(1'b1);
        wr(4'h1, 4'h5);
        wr(4'h2, 4'h2);
        rd_lit(4'h1, 4'h5, "R10 reload lo");
        rd_lit(4'h2, 4'h2, "R10 reload hi");
        rd_lit(4'h9, 4'h0, "R10 ch1 untouched");
        wr(4'h0, 4'h1);
        rd_lit(4'h0, 4'h1, "R2 run readback");
        idle(); idle();
        rd_lit(4'h3, 4'h0, "R2 no change before edge");
        slow_to(1'b0);
        rd_lit(4'h3, 4'h0, "R2 start without decrement");
        slow_to(1'b1);
        rd_lit(4'h3, 4'h0, "R4 rising edge ignored");
        slow_to(1'b0);
        rd_lit(4'h3, 4'h0, "R5 count holds 00 until rise");
        check("R5 irq on underflow", {7'd0, last_irq[0]}, 8'd1);
        slow_to(1'b1);
        rd_lit(4'h3, 4'h5, "R5 reload lo loaded");
        rd_lit(4'h4, 4'h2, "R5 reload hi loaded");
        slow_to(1'b0);
        rd_lit(4'h3, 4'h4, "R4 decrement to 24h");
        rd_lit(4'h0, 4'h9, "R6 irq pending");

        // R3 stop, R6 clear
        wr(4'h0, 4'h8);
        rd_lit(4'h0, 4'h1, "R3 run reads 1 before halt");
        slow_to(1'b1);
        rd_lit(4'h0, 4'h1, "R3 run still 1 after rise");
        slow_to(1'b0);
        rd_lit(4'h0, 4'h0, "R3 halted, R6 cleared");
        rd_lit(4'h3, 4'h3, "R3 one extra decrement");
        slow_to(1'b1); slow_to(1'b0);
        rd_lit(4'h3, 4'h3, "R3 count frozen");

        // ch1: fast source, output enabled, reload 10h
        wr(4'h9, 4'h0);
        wr(4'hA, 4'h1);
        wr(4'h8, 4'h7);
        slow_to(1'b1); slow_to(1'b0); slow_to(1'b1); slow_to(1'b0);
        rd_lit(4'h8, 4'h7, "R7 slow edges ignored by ch1");
        fast_to(1'b1); fast_to(1'b0);
        fast_to(1'b1); fast_to(1'b0);
        idle();
        check("R9 tout toggled on", {7'd0, last_tout[1]}, 8'd1);
        fast_to(1'b1);
        rd_lit(4'hB, 4'h0, "R8 lo read captures");
        fast_to(1'b0);
        rd_lit(4'hC, 4'h1, "R8 held hi nibble");
        rd_lit(4'hB, 4'hF, "R8 new lo");
        rd_lit(4'hC, 4'h0, "R8 new hi");
        wr(4'h8, 4'h3);
        idle();
        check("R9 gated low", {7'd0, last_tout[1]}, 8'd0);
        wr(4'h8, 4'h7);
        idle();
        check("R9 state kept while gated", {7'd0, last_tout[1]}, 8'd1);
        wr(4'h0, 4'h0);
        check("R6 write 0 keeps ch1 irq", {7'd0, last_irq[1]}, 8'd1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            if ($urandom % 16 == 0) s_lvl = ~s_lvl;
            if ($urandom % 3 == 0)  f_lvl = ~f_lvl;
            r = $urandom % 8;
            if (r == 0)      tick(s_lvl, f_lvl, 1'b1, 1'b0, 4'($urandom), 4'($urandom));
            else if (r < 3)  tick(s_lvl, f_lvl, 1'b0, 1'b1, 4'($urandom), 4'h0);
            else             idle();
        end

        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule